// File: doc/BRIEF.md
# Byte-Port Direct-Mapped Cache with Per-Byte Valid Flags

This block sits between a byte-wide processor memory port and a slow line-wide DRAM controller that needs around ten cycles to answer a read. It keeps 4096 lines of four bytes each, 16 KB in total, with one line per index. Each data entry is 36 bits wide: the four data bytes plus one valid flag for each byte. The address tags are held in a separate array that is 9 bits wide. With the default 23-bit byte address, bits [1:0] select the byte, bits [13:2] select the line index and bits [22:14] form the tag.

A read whose tag matches, and whose byte is valid, is answered combinationally in the same cycle with no wait state. Any other read stalls the processor. The block then fetches the whole line, installs it with all four flags set, and returns the byte in the cycle after the fill. Writes are written through. Every write goes to the backing memory with a one-hot byte enable, and the processor stays stalled until that memory accepts it. A write can validate a single byte of a line without fetching the rest of the line. After reset the block walks every index to clear the valid flags and holds the processor stalled until the walk is done.

Top module: `bytecache_dm`

## Requirements
- R1: From reset release, `cpu_wait` stays high for exactly 2^INDEX_W cycles (one per index), whatever the processor does. After that, every byte reads as a miss until it has been filled or written.
- R2: A read with `cpu_req`=1 and `cpu_we`=0 is a hit when the stored tag for the index in address bits [INDEX_W+1:2] equals address bits [ADDR_W-1:INDEX_W+2] and the valid flag of byte [1:0] is set. A hit completes with `cpu_wait`=0 in the same cycle and `cpu_rdata` holding the stored byte.
- R3: A read miss raises `cpu_wait` and issues `mem_req`=1 with `mem_we`=0 and `mem_addr` set to the byte address shifted right by two. The request and its address are held unchanged until the cycle in which `mem_ready`=1.
- R4: In the cycle in which `mem_ready` accepts a fill, byte k of the line is taken from `mem_rdata[8k+7:8k]`, the tag is written and all four flags are set. `cpu_wait` stays high through that cycle. In the next cycle the same read hits and returns the byte.
- R5: Every write issues `mem_req`=1 and `mem_we`=1 with `mem_be` equal to 1 shifted left by address bits [1:0], and the data byte placed in lane k of `mem_wdata`. `cpu_wait` stays high until the cycle in which `mem_ready`=1, and the write completes in that cycle.
- R6: When a write's tag matches the stored tag, only the addressed byte changes and its flag is set. Bytes that were valid before stay valid and keep their values.
- R7: When a write's tag does not match, the stored tag is replaced, the byte is stored, and only that byte's flag is set. The other three bytes of the line then read as misses.
- R8: A read hit issues no backing request. `mem_req` is low in every cycle in which a processor read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the clearing walk |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid when the read completes |
| cpu_wait | output | 1 | Stall; the access completes on the first edge where this is low |
| mem_req | output | 1 | Backing memory request |
| mem_we | output | 1 | 1 = write-through, 0 = line fetch |
| mem_addr | output | ADDR_W-2 | Line address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data, byte placed in its lane |
| mem_rdata | input | 32 | Line data returned for a fetch |
| mem_ready | input | 1 | Backing memory accepts the current request |

## Verification
The bound checker checks these rules on every cycle: the stall during the clearing walk, a backing request held stable until it is accepted, a one-hot byte enable on every write, a write completing only in the cycle its write-through is accepted, a read completing without backing traffic, and a fetched line hitting in the cycle after its fill. Whether the right byte comes back, and whether a given access should hit or miss, depends on the history of tags and per-byte flags. Only the bench's sweeps can show that. They compare every read with a shadow memory and with a tag/flag model, count stall cycles exactly, and cover partial lines left by conflicting writes.

// File: rtl/bytecache_pkg.sv
package bytecache_pkg;

    localparam int OFF_W      = 2;
    localparam int LINE_BYTES = 1 << OFF_W;
    localparam int LINE_BITS  = 8 * LINE_BYTES;

    typedef enum logic [1:0] {
        ST_SWEEP,
        ST_IDLE,
        ST_FILL,
        ST_WRITE
    } ctl_state_e;

    typedef struct packed {
        logic [LINE_BYTES-1:0] vld;
        logic [LINE_BITS-1:0]  data;
    } line_entry_t;

    localparam int ENTRY_W = $bits(line_entry_t);

endpackage

// File: rtl/bytecache_ram.sv
module bytecache_ram #(
    parameter int W  = 36,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bytecache_lookup.sv
module bytecache_lookup
    import bytecache_pkg::*;
#(
    parameter int TAG_W = 9
) (
    input  line_entry_t      entry,
    input  logic [TAG_W-1:0] stored_tag,
    input  logic [TAG_W-1:0] want_tag,
    input  logic [OFF_W-1:0] sel,
    output logic             tag_match,
    output logic             hit,
    output logic [7:0]       byte_out
);
    always_comb begin
        tag_match = (stored_tag == want_tag);
        hit       = tag_match && entry.vld[sel];
        byte_out  = entry.data[{sel, 3'b000} +: 8];
    end
endmodule

// File: rtl/bytecache_dm.sv
module bytecache_dm
    import bytecache_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int INDEX_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [7:0]              cpu_wdata,
    output logic [7:0]              cpu_rdata,
    output logic                    cpu_wait,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-OFF_W-1:0] mem_addr,
    output logic [LINE_BYTES-1:0]   mem_be,
    output logic [LINE_BITS-1:0]    mem_wdata,
    input  logic [LINE_BITS-1:0]    mem_rdata,
    input  logic                    mem_ready
);
    localparam int TAG_W = ADDR_W - INDEX_W - OFF_W;
    localparam int LINES = 1 << INDEX_W;
    localparam logic [INDEX_W-1:0] LAST_IDX = INDEX_W'(LINES - 1);

    typedef struct packed {
        ctl_state_e          st;
        logic [INDEX_W-1:0]  sweep;
        logic [ADDR_W-1:0]   addr;
        logic [7:0]          wdata;
    } regs_t;

    regs_t q, d;

    // address fields of the live request and of the held request
    logic [INDEX_W-1:0] cpu_idx, q_idx, rd_idx;
    logic [TAG_W-1:0]   cpu_tag, q_tag, cmp_tag;
    logic [OFF_W-1:0]   cpu_byte, q_byte, cmp_byte;

    assign cpu_idx  = cpu_addr[OFF_W +: INDEX_W];
    assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_byte = cpu_addr[OFF_W-1:0];
    assign q_idx    = q.addr[OFF_W +: INDEX_W];
    assign q_tag    = q.addr[ADDR_W-1 -: TAG_W];
    assign q_byte   = q.addr[OFF_W-1:0];

    // in idle the arrays look at the live address, otherwise at the held one
    always_comb begin
        if (q.st == ST_IDLE) begin
            rd_idx   = cpu_idx;
            cmp_tag  = cpu_tag;
            cmp_byte = cpu_byte;
        end else begin
            rd_idx   = q_idx;
            cmp_tag  = q_tag;
            cmp_byte = q_byte;
        end
    end

    // arrays
    logic               wr_en;
    logic [INDEX_W-1:0] wr_idx;
    line_entry_t        wr_entry, rd_entry;
    logic [TAG_W-1:0]   wr_tag, rd_tag;
    logic [ENTRY_W-1:0] rd_entry_raw;

    bytecache_ram #(.W(ENTRY_W), .AW(INDEX_W)) u_data (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_idx),
        .wdata (wr_entry),
        .raddr (rd_idx),
        .rdata (rd_entry_raw)
    );
    assign rd_entry = line_entry_t'(rd_entry_raw);

    bytecache_ram #(.W(TAG_W), .AW(INDEX_W)) u_tag (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_idx),
        .wdata (wr_tag),
        .raddr (rd_idx),
        .rdata (rd_tag)
    );

    logic tag_match, hit;

    bytecache_lookup #(.TAG_W(TAG_W)) u_look (
        .entry      (rd_entry),
        .stored_tag (rd_tag),
        .want_tag   (cmp_tag),
        .sel        (cmp_byte),
        .tag_match  (tag_match),
        .hit        (hit),
        .byte_out   (cpu_rdata)
    );

    // held write byte steered into its lane
    logic [LINE_BYTES-1:0] lane_mask;
    logic [LINE_BITS-1:0]  lane_data, lane_keep;

    always_comb begin
        lane_mask = LINE_BYTES'(1) << q_byte;
        lane_data = LINE_BITS'(q.wdata) << {q_byte, 3'b000};
        lane_keep = ~(LINE_BITS'(8'hFF) << {q_byte, 3'b000});
    end

    always_comb begin
        d         = q;
        wr_en     = 1'b0;
        wr_idx    = q_idx;
        wr_entry  = '0;
        wr_tag    = q_tag;
        cpu_wait  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_be    = '0;
        mem_wdata = '0;
        mem_addr  = q.addr[ADDR_W-1:OFF_W];

        unique case (q.st)
            ST_SWEEP: begin
                cpu_wait = 1'b1;
                wr_en    = 1'b1;
                wr_idx   = q.sweep;
                wr_tag   = '0;
                d.sweep  = q.sweep + 1'b1;
                if (q.sweep == LAST_IDX) begin
                    d.st = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (cpu_req) begin
                    d.addr  = cpu_addr;
                    d.wdata = cpu_wdata;
                    if (cpu_we) begin
                        cpu_wait = 1'b1;
                        d.st     = ST_WRITE;
                    end else if (!hit) begin
                        cpu_wait = 1'b1;
                        d.st     = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                cpu_wait = 1'b1;
                mem_req  = 1'b1;
                if (mem_ready) begin
                    wr_en         = 1'b1;
                    wr_entry.vld  = '1;
                    wr_entry.data = mem_rdata;
                    d.st          = ST_IDLE;
                end
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = lane_mask;
                mem_wdata = lane_data;
                cpu_wait  = !mem_ready;
                if (mem_ready) begin
                    wr_en         = 1'b1;
                    wr_entry.data = (rd_entry.data & lane_keep) | lane_data;
                    wr_entry.vld  = tag_match ? (rd_entry.vld | lane_mask) : lane_mask;
                    d.st          = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_SWEEP, default: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/bytecache_dm_chk.sv
module bytecache_dm_chk #(
    parameter int ADDR_W  = 23,
    parameter int INDEX_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wait,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-3:0] mem_addr,
    input logic [3:0]        mem_be,
    input logic              mem_ready
);
    localparam int LINES = 1 << INDEX_W;
    localparam logic [INDEX_W:0] LINES_C = (INDEX_W+1)'(LINES);

    // cycles since reset release, saturating after the clearing walk
    logic [INDEX_W:0] cyc_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != LINES_C) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    AST_SWEEP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < LINES_C) |-> cpu_wait); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) ##1 (cpu_req && !cpu_we && $stable(cpu_addr)) |-> !cpu_wait); // R4

    AST_BE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1)); // R5

    AST_WRITE_DONE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_wait) |-> (mem_req && mem_we && mem_ready)); // R5

    AST_HIT_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_wait) |-> !mem_req); // R8
endmodule

bind bytecache_dm bytecache_dm_chk #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_chk (.*);

// File: tb/bytecache_dm_test.sv
module bytecache_dm_test;
    localparam int AW    = 9;
    localparam int IW    = 4;
    localparam int LINES = 1 << IW;
    localparam int BYTES = 1 << AW;
    localparam int LAT   = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_wait;
    logic        mem_req, mem_we;
    logic [AW-3:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #10 clk = ~clk;

    bytecache_dm #(.ADDR_W(AW), .INDEX_W(IW)) uut (.*);

    int checks = 0;
    int fails  = 0;

    // backing memory, bench shadow, and the tag/flag model
    logic [7:0] back [BYTES];
    logic [7:0] shadow [BYTES];
    int         m_tag [LINES];
    bit         m_vld [LINES][4];

    int n_rd = 0, n_wr = 0, cnt = 0;
    logic [3:0]  obs_be;
    logic [31:0] obs_wdata;
    logic [AW-3:0] obs_addr;

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            cnt = 0;
        end else if (mem_req) begin
            if (cnt == LAT - 1) begin
                mem_ready = 1'b1;
                if (mem_we) begin
                    n_wr++;
                    obs_be = mem_be;
                    obs_wdata = mem_wdata;
                    obs_addr = mem_addr;
                    for (int k = 0; k < 4; k++)
                        if (mem_be[k]) back[{mem_addr, 2'(k)}] = mem_wdata[8*k +: 8];
                end else begin
                    n_rd++;
                    for (int k = 0; k < 4; k++)
                        mem_rdata[8*k +: 8] = back[{mem_addr, 2'(k)}];
                end
            end else begin
                cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_read(input int a, input string req);
        int waits, rd0, idx, tg, b;
        bit exp_hit;
        logic [7:0] got;
        idx = (a >> 2) % LINES;
        tg  = a >> (IW + 2);
        b   = a & 3;
        exp_hit = (m_tag[idx] == tg) && m_vld[idx][b];
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = AW'(a);
        rd0 = n_rd; waits = 0;
        #1;
        while (cpu_wait) begin
            waits++;
            @(negedge clk); #1;
        end
        got = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0;
        check(got == shadow[a], {req, " data R4"}, got, shadow[a]);
        if (exp_hit) begin
            check(waits == 0, {req, " hit R2"}, waits, 0);
            check(n_rd == rd0, {req, " hit traffic R8"}, n_rd - rd0, 0);
        end else begin
            check(waits == LAT + 1, {req, " miss stall R3"}, waits, LAT + 1);
            check(n_rd == rd0 + 1, {req, " miss fetch R3"}, n_rd - rd0, 1);
            m_tag[idx] = tg;
            for (int k = 0; k < 4; k++) m_vld[idx][k] = 1'b1;
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] v);
        int waits, wr0, idx, tg, b;
        idx = (a >> 2) % LINES;
        tg  = a >> (IW + 2);
        b   = a & 3;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = AW'(a); cpu_wdata = v;
        wr0 = n_wr; waits = 0;
        #1;
        while (cpu_wait) begin
            waits++;
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        check(waits == LAT, "R5 write stall", waits, LAT);
        check(n_wr == wr0 + 1, "R5 write forwarded", n_wr - wr0, 1);
        check(obs_be == 4'(1 << b), "R5 byte enable", obs_be, 1 << b);
        check(obs_wdata[8*b +: 8] == v, "R5 lane data", obs_wdata[8*b +: 8], v);
        check(obs_addr == (AW-2)'(a >> 2), "R5 line address", obs_addr, a >> 2);
        shadow[a] = v;
        if (m_tag[idx] == tg) begin
            m_vld[idx][b] = 1'b1;
        end else begin
            m_tag[idx] = tg;
            for (int k = 0; k < 4; k++) m_vld[idx][k] = (k == b);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ (a >> 3));
    endfunction

    initial begin
        int hi;
        for (int i = 0; i < BYTES; i++) begin
            back[i] = pat(i);
            shadow[i] = pat(i);
        end
        for (int i = 0; i < LINES; i++) begin
            m_tag[i] = -1;
            for (int k = 0; k < 4; k++) m_vld[i][k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        #1;
        check(cpu_wait == 1'b1, "R1 wait in reset", cpu_wait, 1);
        check(mem_req == 1'b0, "R1 no request in reset", mem_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        hi = 0;
        #1;
        while (cpu_wait && hi < 10 * LINES) begin
            hi++;
            @(negedge clk); #1;
        end
        check(hi == LINES, "R1 clearing walk length", hi, LINES);

        // every byte in order: one miss per line, then hits
        for (int a = 0; a < BYTES; a++) do_read(a, "seq");
        // scattered reads with tag conflicts
        for (int i = 0; i < 96; i++) do_read((i * 77 + 5) % BYTES, "scatter");

        // writes: matching tag, then conflicting tag, with read-back of the line
        for (int i = 0; i < 24; i++) begin
            int a, c, idx;
            a = (i * 53 + 2) % BYTES;
            do_read(a, "pre");
            do_write(a, 8'(i ^ 8'h5A));
            idx = (a >> 2) % LINES;
            check(m_vld[idx][(a & 3) ^ 1] == 1'b1, "R6 neighbour kept valid", m_vld[idx][(a & 3) ^ 1], 1);
            do_read(a, "R6 written byte");
            do_read(a ^ 1, "R6 neighbour");
            c = a ^ (1 << (IW + 2));
            do_write(c, 8'(i + 8'h90));
            do_read(c, "R7 written byte");
            do_read(c ^ 2, "R7 other byte");
            do_read(a, "R7 evicted line");
        end

        // cold-line write: only the written byte may hit
        for (int i = 0; i < 8; i++) begin
            int a;
            a = ((i * 3) % LINES) * 4 + (i & 3) + (((i + 5) % 8) << (IW + 2));
            do_write(a, 8'(8'hC0 + i));
            do_read(a, "R7 partial hit");
            do_read(a ^ 3, "R7 partial miss");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule